// File: doc/BRIEF.md
# SPI Host Chip-Select Sequencer

This block owns the four active-low peripheral select lines of an SPI host and decides when a new transfer may begin. A single configuration word sets several things: host or client operation, how the 4-bit selection code maps onto the pins, an inter-select gap, which clock enable times that gap, and whether a start must wait for unread receive data to be drained. Writes to the configuration word can be blocked by a write-protect input.

The shift engine raises `start_req` to ask for a transfer and pulses `xfer_done` when the transfer ends. A request is accepted only in certain conditions: the block is idle and in host mode, the code is not all ones, the gap since the last deselect has run out, and (when enabled) no unread receive data is held. A request that cannot be granted yet is remembered until it can be granted. The block also reports which of four per-select configuration slots applies to the current code.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset `cs_n` is 1111, `busy` is 0 and `mode_q` is all zeros.
- R2: Configuration word layout: bit 0 host enable, bit 1 decode enable, bit 2 alternate gap clock, bit 3 wait-for-read, bits 7:4 selection code, bits 15:8 gap length. With decode off, only the lowest zero bit of the code drives its select line low: xxx0→1110, xx01→1101, x011→1011, 0111→0111.
- R3: With decode on, `cs_n` equals the selection code during a transfer.
- R4: Code 1111 never starts a transfer in either mode; a request made with it stays pending and is granted once a legal code is written.
- R5: `cfg_slot` is the index of the lowest zero code bit with decode off, and code bits 3:2 with decode on.
- R6: With the peripheral clock as gap source, a pending request after a deselect leaves `cs_n` at 1111 for exactly max(gap, 6) cycles.
- R7: With the alternate gap clock selected, the gap counts only cycles where `gclk_en` is high.
- R8: With wait-for-read set, no transfer starts while `rx_full` is high; with it clear, `rx_full` has no effect.
- R9: While `wr_protect` is high, configuration writes leave `mode_q` unchanged.
- R10: With host enable clear, `cs_n` stays 1111 and no transfer starts; a request stays pending.
- R11: The first request after reset is granted at once: `busy` and `cs_n` change one cycle after `start_req`.
- R12: A `start_req` seen while `busy` is ignored, and `cs_n` is 1111 whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 16 | Configuration word to write |
| wr_protect | input | 1 | Blocks configuration writes when high |
| start_req | input | 1 | Request for a new transfer |
| xfer_done | input | 1 | End of the current transfer |
| rx_full | input | 1 | Receive holding register has unread data |
| gclk_en | input | 1 | Alternate clock enable for gap timing |
| cs_n | output | 4 | Active-low select lines |
| busy | output | 1 | A transfer is in progress |
| cfg_slot | output | 2 | Configuration slot of the current code |
| mode_q | output | 16 | Current configuration word |

## Verification
The code mapping is walked across both decode settings with codes whose lowest zero sits at every position, and with upper bits set or clear, so that a priority encoder is told apart from a plain bit copy and from one that looks at the wrong end. Gap lengths below, at and above the floor of six tell a clamped count from a raw or an off-by-one count, and a sparse `gclk_en` tells the alternate source from the peripheral clock. Blocked requests (illegal code, client mode, unread data) are then released to show that the request was held rather than dropped.

// File: rtl/spi_cs_pkg.sv
// Shared widths and the configuration word layout of the chip-select sequencer.
package spi_cs_pkg;
    localparam int CS_W   = 4;
    localparam int GAP_W  = 8;
    localparam int SLOT_W = 2;

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic [CS_W-1:0]  code;
        logic             wait_rd;
        logic             alt_clk;
        logic             decode;
        logic             host;
    } cs_cfg_t;

    localparam int CFG_W = $bits(cs_cfg_t);
endpackage

// File: rtl/spi_cs_cfg_reg.sv
// Configuration word register.
// Assumes: a write is taken on any cycle with the strobe high and protection low.
module spi_cs_cfg_reg #(
    parameter int CFG_W = spi_cs_pkg::CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_protect,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q
);
    // Hold the word; protected writes are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en && !wr_protect)
            cfg_q <= wr_data;
    end
endmodule

// File: rtl/spi_cs_decode.sv
// Maps a selection code onto select-line levels and a configuration slot.
// Assumes: the all-ones code names no peripheral in either mode.
module spi_cs_decode #(
    parameter int CS_W   = spi_cs_pkg::CS_W,
    parameter int SLOT_W = spi_cs_pkg::SLOT_W
) (
    input  logic [CS_W-1:0]   code,
    input  logic              decode_en,
    output logic [CS_W-1:0]   pattern,
    output logic              legal,
    output logic [SLOT_W-1:0] slot
);
    // Priority one-cold mapping or raw pass-through, plus slot choice.
    always_comb begin
        logic found;
        found   = 1'b0;
        legal   = (code != {CS_W{1'b1}});
        pattern = {CS_W{1'b1}};
        slot    = '0;
        if (decode_en) begin
            pattern = code;
            slot    = code[CS_W-1 -: SLOT_W];
        end else begin
            for (int i = 0; i < CS_W; i++) begin
                if (!found && !code[i]) begin
                    pattern[i] = 1'b0;
                    slot       = SLOT_W'(i);
                    found      = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_cs_gap_timer.sv
// Counts down the minimum inactive time between two selects.
// Assumes: load wins over tick; the timer is expired out of reset.
module spi_cs_gap_timer #(
    parameter int GAP_W   = spi_cs_pkg::GAP_W,
    parameter int MIN_GAP = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] gap_val,
    input  logic             tick,
    output logic             expired
);
    localparam logic [GAP_W-1:0] MIN_V = GAP_W'(MIN_GAP);

    logic [GAP_W-1:0] cnt_q;
    logic [GAP_W-1:0] eff_gap;

    // Raise short programmed gaps to the floor.
    always_comb eff_gap = (gap_val < MIN_V) ? MIN_V : gap_val;

    // Load on deselect, then count source ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= eff_gap - 1'b1;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/spi_cs_sequencer.sv
// Chip-select sequencer of an SPI host: holds the configuration word, grants
// transfer requests and drives the active-low select lines.
// Assumes: xfer_done is only meaningful while busy; blocked requests are kept.
module spi_cs_sequencer #(
    parameter int MIN_GAP = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wr_en,
    input  logic [spi_cs_pkg::CFG_W-1:0] cfg_wr_data,
    input  logic                         wr_protect,
    input  logic                         start_req,
    input  logic                         xfer_done,
    input  logic                         rx_full,
    input  logic                         gclk_en,
    output logic [spi_cs_pkg::CS_W-1:0]  cs_n,
    output logic                         busy,
    output logic [spi_cs_pkg::SLOT_W-1:0] cfg_slot,
    output logic [spi_cs_pkg::CFG_W-1:0] mode_q
);
    import spi_cs_pkg::*;

    cs_cfg_t          cfg;
    logic [CS_W-1:0]  pattern;
    logic             legal;
    logic             gap_ok;
    logic             gap_tick;
    logic             grant;
    logic             pending_q;
    logic             busy_q;
    logic [CS_W-1:0]  cs_q;

    spi_cs_cfg_reg #(.CFG_W(CFG_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_protect(wr_protect),
        .wr_data(cfg_wr_data), .cfg_q(mode_q)
    );

    assign cfg = cs_cfg_t'(mode_q);

    spi_cs_decode #(.CS_W(CS_W), .SLOT_W(SLOT_W)) dec_i (
        .code(cfg.code), .decode_en(cfg.decode), .pattern(pattern),
        .legal(legal), .slot(cfg_slot)
    );

    // Gap source: every cycle, or only alternate-clock enable cycles.
    always_comb gap_tick = cfg.alt_clk ? gclk_en : 1'b1;

    spi_cs_gap_timer #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) gap_i (
        .clk(clk), .rst_n(rst_n), .load(busy_q && xfer_done),
        .gap_val(cfg.gap), .tick(gap_tick), .expired(gap_ok)
    );

    // Grant when idle, requested, in host mode, legal, gap over, data read.
    always_comb
        grant = !busy_q && (pending_q || start_req) && cfg.host && legal &&
                gap_ok && !(cfg.wait_rd && rx_full);

    // Request memory and transfer state with latched select pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            busy_q    <= 1'b0;
            cs_q      <= {CS_W{1'b1}};
        end else begin
            pending_q <= grant ? 1'b0 : (pending_q || (start_req && !busy_q));
            if (grant) begin
                busy_q <= 1'b1;
                cs_q   <= pattern;
            end else if (busy_q && xfer_done) begin
                busy_q <= 1'b0;
                cs_q   <= {CS_W{1'b1}};
            end
        end
    end

    assign cs_n = cfg.host ? cs_q : {CS_W{1'b1}};
    assign busy = busy_q;
endmodule

// File: rtl/spi_cs_sequencer_chk.sv
// Property checker for the chip-select sequencer, bound to its top.
// Assumes: configuration layout of spi_cs_pkg (bit 0 host, bit 3 wait-for-read).
module spi_cs_sequencer_chk #(
    parameter int MIN_GAP = 6
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_wr_en,
    input logic                         wr_protect,
    input logic                         rx_full,
    input logic [spi_cs_pkg::CS_W-1:0]  cs_n,
    input logic                         busy,
    input logic [spi_cs_pkg::CFG_W-1:0] mode_q
);
    logic [8:0] idle_run;
    logic       busy_d;
    logic       seen_fall;

    // Count idle cycles since the last transfer and note a first deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_run  <= '0;
            busy_d    <= 1'b0;
            seen_fall <= 1'b0;
        end else begin
            busy_d <= busy;
            if (busy_d && !busy) seen_fall <= 1'b1;
            if (busy) idle_run <= '0;
            else if (idle_run != '1) idle_run <= idle_run + 1'b1;
        end
    end

    p_no_forbidden_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mode_q[0] |-> cs_n != 4'hF);
    p_gap_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && seen_fall |-> idle_run >= 9'(MIN_GAP));
    p_wait_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !($past(mode_q[3]) && $past(rx_full)));
    p_wp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_protect && cfg_wr_en |=> $stable(mode_q));
    p_client_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[0] |-> cs_n == 4'hF);
    p_idle_inactive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n == 4'hF);
endmodule

bind spi_cs_sequencer spi_cs_sequencer_chk #(.MIN_GAP(MIN_GAP)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .wr_protect(wr_protect),
    .rx_full(rx_full), .cs_n(cs_n), .busy(busy), .mode_q(mode_q)
);

// File: tb/spi_cs_sequencer_tb_top.sv
// Self-checking bench: vector table for the code mapping, then directed tests.
module spi_cs_sequencer_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_data = '0;
    logic        wr_protect = 1'b0;
    logic        start_req = 1'b0;
    logic        xfer_done = 1'b0;
    logic        rx_full = 1'b0;
    logic        gclk_en = 1'b0;
    logic [3:0]  cs_n;
    logic        busy;
    logic [1:0]  cfg_slot;
    logic [15:0] mode_q;
    logic [1:0]  gdiv = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_cs_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .wr_protect(wr_protect), .start_req(start_req), .xfer_done(xfer_done),
        .rx_full(rx_full), .gclk_en(gclk_en), .cs_n(cs_n), .busy(busy),
        .cfg_slot(cfg_slot), .mode_q(mode_q)
    );

    // Alternate clock enable: one cycle in four.
    always @(negedge clk) begin
        gdiv    <= gdiv + 1'b1;
        gclk_en <= (gdiv == 2'd3);
    end

    // Vector: [10] decode, [9:6] code, [5:2] expected cs_n, [1:0] expected slot.
    localparam logic [10:0] VEC [11] = '{
        {1'b0, 4'b0000, 4'b1110, 2'd0},
        {1'b0, 4'b1010, 4'b1110, 2'd0},
        {1'b0, 4'b0101, 4'b1101, 2'd1},
        {1'b0, 4'b1011, 4'b1011, 2'd2},
        {1'b0, 4'b0011, 4'b1011, 2'd2},
        {1'b0, 4'b0111, 4'b0111, 2'd3},
        {1'b1, 4'b0000, 4'b0000, 2'd0},
        {1'b1, 4'b0101, 4'b0101, 2'd1},
        {1'b1, 4'b1001, 4'b1001, 2'd2},
        {1'b1, 4'b1110, 4'b1110, 2'd3},
        {1'b1, 4'b0011, 4'b0011, 2'd0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [7:0] gap, input logic [3:0] code,
                                       input logic wrd, input logic alt,
                                       input logic dec, input logic host);
        return {gap, code, wrd, alt, dec, host};
    endfunction

    task automatic write_cfg(input logic [15:0] w);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = w;
        tick();
        cfg_wr_en   = 1'b0;
    endtask

    task automatic acquire();
        start_req = 1'b1;
        for (int i = 0; i < 400 && !busy; i++) tick();
        start_req = 1'b0;
    endtask

    task automatic end_xfer();
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
    endtask

    // Number of cycles cs_n stays inactive between two back-to-back transfers.
    task automatic measure_gap(input logic [15:0] w, output int n);
        write_cfg(w);
        acquire();
        end_xfer();
        n = 0;
        start_req = 1'b1;
        for (int i = 0; i < 400; i++) begin
            if (busy) break;
            if (cs_n == 4'hF) n++;
            tick();
            start_req = 1'b0;
        end
        start_req = 1'b0;
        end_xfer();
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 cs_n", 32'(cs_n), 32'hF);
        chk("R1 busy", 32'(busy), 32'h0);
        chk("R1 mode_q", 32'(mode_q), 32'h0);

        // R11 first request granted without delay
        write_cfg(mk(8'd0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1));
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        chk("R11 busy", 32'(busy), 32'h1);
        chk("R11 cs_n", 32'(cs_n), 32'hE);
        end_xfer();

        // R2 R3 R5 mapping table
        for (int v = 0; v < 11; v++) begin
            write_cfg(mk(8'd0, VEC[v][9:6], 1'b0, 1'b0, VEC[v][10], 1'b1));
            chk(VEC[v][10] ? "R5 slot decode" : "R5 slot direct",
                32'(cfg_slot), 32'(VEC[v][1:0]));
            acquire();
            chk(VEC[v][10] ? "R3 cs_n decode" : "R2 cs_n direct",
                32'(cs_n), 32'(VEC[v][5:2]));
            end_xfer();
            chk("R12 idle after done", 32'(cs_n), 32'hF);
        end

        // R4 forbidden code held pending, released by a legal code
        repeat (8) tick();
        write_cfg(mk(8'd0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b1));
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        repeat (8) tick();
        chk("R4 no start busy", 32'(busy), 32'h0);
        chk("R4 no start cs_n", 32'(cs_n), 32'hF);
        write_cfg(mk(8'd0, 4'b0111, 1'b0, 1'b0, 1'b0, 1'b1));
        tick();
        chk("R4 pending granted", 32'(busy), 32'h1);
        chk("R4 cs_n", 32'(cs_n), 32'h7);
        end_xfer();
        // decode mode all-ones also blocked
        repeat (8) tick();
        write_cfg(mk(8'd0, 4'b1111, 1'b0, 1'b0, 1'b1, 1'b1));
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        repeat (4) tick();
        chk("R4 decode all-ones blocked", 32'(busy), 32'h0);
        write_cfg(mk(8'd0, 4'b1100, 1'b0, 1'b0, 1'b1, 1'b1));
        tick();
        chk("R4 decode released", 32'(cs_n), 32'hC);
        end_xfer();

        // R6 gap length with the peripheral clock
        measure_gap(mk(8'd0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1), n);
        chk("R6 gap 0", 32'(n), 32'd6);
        measure_gap(mk(8'd5, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1), n);
        chk("R6 gap 5", 32'(n), 32'd6);
        measure_gap(mk(8'd6, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1), n);
        chk("R6 gap 6", 32'(n), 32'd6);
        measure_gap(mk(8'd7, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1), n);
        chk("R6 gap 7", 32'(n), 32'd7);
        measure_gap(mk(8'd40, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1), n);
        chk("R6 gap 40", 32'(n), 32'd40);

        // R7 alternate clock: six ticks at one in four cycles
        measure_gap(mk(8'd6, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1), n);
        chk("R7 alt gap in range", 32'(n >= 18 && n <= 21), 32'h1);

        // R8 wait for read
        repeat (8) tick();
        write_cfg(mk(8'd0, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1));
        rx_full = 1'b1;
        repeat (8) tick();
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        repeat (4) tick();
        chk("R8 held by unread data", 32'(busy), 32'h0);
        rx_full = 1'b0;
        tick();
        chk("R8 granted after read", 32'(busy), 32'h1);
        end_xfer();
        write_cfg(mk(8'd0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1));
        rx_full = 1'b1;
        acquire();
        chk("R8 unread ignored when off", 32'(busy), 32'h1);
        end_xfer();
        rx_full = 1'b0;

        // R9 write protection
        write_cfg(16'h1201);
        wr_protect = 1'b1;
        write_cfg(16'h3471);
        chk("R9 protected write dropped", 32'(mode_q), 32'h1201);
        wr_protect = 1'b0;
        write_cfg(16'h3471);
        chk("R9 write taken", 32'(mode_q), 32'h3471);

        // R12 start while busy ignored
        write_cfg(mk(8'd0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1));
        acquire();
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        end_xfer();
        repeat (12) tick();
        chk("R12 busy after ignored start", 32'(busy), 32'h0);
        chk("R12 cs_n after ignored start", 32'(cs_n), 32'hF);

        // R10 client mode
        write_cfg(mk(8'd0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0));
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        repeat (3) tick();
        chk("R10 client cs_n", 32'(cs_n), 32'hF);
        chk("R10 client busy", 32'(busy), 32'h0);
        write_cfg(mk(8'd0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1));
        tick();
        chk("R10 pending granted in host", 32'(cs_n), 32'hE);
        end_xfer();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule